// File: doc/BRIEF.md
# PTP residence time stamper

This block sits in the byte-wide frame path of a node that belongs to a distributed end-to-end one-step transparent clock. Every node sees the same free-running 64-bit nanosecond time. In ingress mode the block finds PTP event frames and writes the low 32 bits of the time at which the frame's first byte arrived into the four reserved bytes of the PTP common header. The frame then carries its own arrival time across the network.

In egress mode the block reads those 32 bits back. It rebuilds the full 64-bit arrival time, allowing for at most one wrap of the low word, and subtracts it from the local time at the frame's first byte. It adds a fixed calibration constant and accumulates the result into the correctionField. It then clears the reserved bytes so that the frame leaves in a conformant state.

Frames arrive and leave on AXI4-Stream. Bytes are held in a short queue that is one header field span deep. This lets the correctionField be rewritten before its first byte is released. Untunnelled Ethernet is handled, as is IPv4 with a plain 20-byte header carrying UDP. A per-frame sideband marks classified and stamped frames on the last beat.

Top module: `ptp_residence_stamper`

## Requirements
- R1: A frame is classified as PTP in two cases. The first is EtherType 0x88F7 in bytes 12-13, with the PTP header starting at byte 14. The second is EtherType 0x0800 with byte 14 = 0x45, byte 23 = 17 (UDP) and UDP destination port (bytes 36-37, big-endian) 319 or 320, with the PTP header starting at byte 42. m_tuser[0] is high on the last beat of a classified frame.
- R2: Only event frames are modified. An event frame arrives on the EtherType path or on port 319, and its messageType (low nibble of header byte 0) is 0 (Sync) or 1 (Delay_Req). Port 320 frames and other message types leave byte-for-byte unchanged. m_tuser[1] is high on the last beat of a modified frame.
- R3: In ingress mode a modified frame has header bytes 16-19 replaced by bits 31:0 of time_ns, most significant byte first. The time is sampled on the beat that accepts the frame's first byte. The correctionField is left untouched.
- R4: In egress mode the arrival time is rebuilt from the stored 32 bits and bits 63:32 of the time sampled at the first byte. When the stored value exceeds bits 31:0 of that time, the upper word is reduced by one.
- R5: In egress mode the correctionField of a modified frame (header bytes 8-15, big-endian, nanoseconds times 2^16) is increased by (now - rebuilt + cal_ns) * 2^16, modulo 2^64.
- R6: In egress mode header bytes 16-19 of a modified frame leave as zero.
- R7: Frames that are not PTP leave with the same length, the same bytes and the same tlast position. Frames also leave in arrival order.
- R8: While m_tvalid is high and m_tready is low, m_tvalid, m_tdata and m_tlast hold their values. No byte is lost or duplicated under output backpressure.
- R9: The queue holds 12 bytes. A byte is released once the queue is full or once the last byte of a frame is queued. A frame shorter than the queue therefore still leaves in full.
- R10: After reset m_tvalid is low and s_tready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| egress_mode | input | 1 | 0 = write arrival time, 1 = compute residence and clear |
| cal_ns | input | CAL_W | Fixed bias in ns added to each residence time |
| time_ns | input | 64 | Free-running common nanosecond time |
| s_tdata | input | 8 | Input stream byte |
| s_tvalid | input | 1 | Input byte valid |
| s_tready | output | 1 | Input byte accepted |
| s_tlast | input | 1 | Last byte of input frame |
| m_tdata | output | 8 | Output stream byte |
| m_tvalid | output | 1 | Output byte valid |
| m_tready | input | 1 | Output byte accepted |
| m_tlast | output | 1 | Last byte of output frame |
| m_tuser | output | 2 | On the last beat: bit 0 PTP, bit 1 modified |

## Verification
On every cycle the assertions check several things. The output holds steady under backpressure. The queue never overfills and never holds more finished frames than it has slots. A modified mark never appears without a PTP mark. At the moment of a rewrite, all twelve tagged field bytes are still queued. Only the bench's frames can show the values themselves: the arrival-time bytes, residence sums across a 32-bit wrap and across a 64-bit carry, and the calibration offset. The bench also covers port 320 and non-event frames left untouched, and bit-exact pass-through of other traffic, both with and without random output stalls.

// File: rtl/ptp_rts_pkg.sv
// Shared offsets, tag codes and the queue slot type for the residence stamper.
// Assumes untagged Ethernet and IPv4 headers without options.
package ptp_rts_pkg;
    localparam int HDR_L2     = 14;   // PTP header start, EtherType path
    localparam int HDR_UDP    = 42;   // PTP header start, IPv4/UDP path
    localparam int CORR_OFF   = 8;    // correctionField offset in header
    localparam int RSV_OFF    = 16;   // reserved stamp field offset
    localparam int LAST_OFF   = RSV_OFF + 3;
    localparam int FIELD_SPAN = LAST_OFF + 1 - CORR_OFF;
    localparam int CNT_W      = $clog2(HDR_UDP + LAST_OFF + 2);

    localparam logic [3:0] ROLE_NONE  = 4'd0;
    localparam logic [3:0] ROLE_CORR0 = 4'd1;  // +k for correction byte k (MSB first)
    localparam logic [3:0] ROLE_RSV0  = 4'd9;  // +k for reserved byte k (MSB first)

    typedef struct packed {
        logic [7:0] data;
        logic       last;
        logic [1:0] user;
        logic [3:0] role;
    } slot_t;
endpackage

// File: rtl/ptp_rts_parser.sv
// Walks each accepted byte of a frame, classifies the frame and tags the bytes
// of the correction and reserved fields of event messages. Assumes the
// input bytes of one frame arrive in order and tlast closes every frame.
module ptp_rts_parser
    import ptp_rts_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        beat,
    input  logic [7:0]  data,
    input  logic        last,
    input  logic [63:0] time_ns,
    output logic [3:0]  role,
    output logic        patch,
    output logic [1:0]  flags,
    output logic [63:0] ts
);
    localparam logic [CNT_W-1:0] C_ET_HI  = CNT_W'(12);
    localparam logic [CNT_W-1:0] C_ET_LO  = CNT_W'(13);
    localparam logic [CNT_W-1:0] C_IHL    = CNT_W'(14);
    localparam logic [CNT_W-1:0] C_PROTO  = CNT_W'(23);
    localparam logic [CNT_W-1:0] C_DP_HI  = CNT_W'(36);
    localparam logic [CNT_W-1:0] C_DP_LO  = CNT_W'(37);
    localparam logic [CNT_W-1:0] C_L2     = CNT_W'(HDR_L2);
    localparam logic [CNT_W-1:0] C_UDP    = CNT_W'(HDR_UDP);
    localparam logic [CNT_W-1:0] C_CORR   = CNT_W'(CORR_OFF);
    localparam logic [CNT_W-1:0] C_CEND   = CNT_W'(CORR_OFF + 7);
    localparam logic [CNT_W-1:0] C_RSV    = CNT_W'(RSV_OFF);
    localparam logic [CNT_W-1:0] C_LAST   = CNT_W'(LAST_OFF);

    logic [CNT_W-1:0] cnt_q;
    logic [15:0]      etype_q, dport_q;
    logic             ihl_ok_q, udp_q, stamped_q;
    logic [3:0]       mtype_q;
    logic [63:0]      ts_q;

    logic             is_l2, is_udp, port_ptp, evt_path, ptp_known, in_hdr, tag;
    logic [CNT_W-1:0] hbase, off;
    logic [3:0]       cur_mt;

    // Classify the frame from the fields captured so far and tag this byte.
    always_comb begin
        is_l2     = (etype_q == 16'h88F7);
        is_udp    = (etype_q == 16'h0800) && ihl_ok_q && udp_q;
        port_ptp  = (dport_q == 16'd319) || (dport_q == 16'd320);
        evt_path  = is_l2 || (dport_q == 16'd319);
        ptp_known = (is_l2 && cnt_q >= C_L2) || (is_udp && port_ptp && cnt_q > C_DP_LO);
        hbase     = is_l2 ? C_L2 : C_UDP;
        off       = cnt_q - hbase;
        in_hdr    = ptp_known && evt_path && (cnt_q >= hbase) && (off <= C_LAST);
        cur_mt    = (off == '0) ? data[3:0] : mtype_q;
        tag       = in_hdr && (cur_mt <= 4'd1);
        role      = ROLE_NONE;
        if (tag && off >= C_CORR && off <= C_CEND)
            role = ROLE_CORR0 + 4'(off - C_CORR);
        else if (tag && off >= C_RSV)
            role = ROLE_RSV0 + 4'(off - C_RSV);
        patch = beat && tag && (off == C_LAST);
        flags = {stamped_q | patch, ptp_known};
        ts    = ts_q;
    end

    // Track the byte position and capture header fields of the frame in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            etype_q   <= '0;
            dport_q   <= '0;
            ihl_ok_q  <= 1'b0;
            udp_q     <= 1'b0;
            stamped_q <= 1'b0;
            mtype_q   <= '0;
            ts_q      <= '0;
        end else if (beat) begin
            if (cnt_q == '0)
                ts_q <= time_ns;
            if (last) begin
                cnt_q     <= '0;
                etype_q   <= '0;
                dport_q   <= '0;
                ihl_ok_q  <= 1'b0;
                udp_q     <= 1'b0;
                stamped_q <= 1'b0;
            end else begin
                if (cnt_q != '1)
                    cnt_q <= cnt_q + 1'b1;
                case (cnt_q)
                    C_ET_HI: etype_q[15:8] <= data;
                    C_ET_LO: etype_q[7:0]  <= data;
                    C_IHL:   ihl_ok_q      <= (data == 8'h45);
                    C_PROTO: udp_q         <= (data == 8'd17);
                    C_DP_HI: dport_q[15:8] <= data;
                    C_DP_LO: dport_q[7:0]  <= data;
                    default: ;
                endcase
                if (in_hdr && off == '0)
                    mtype_q <= data[3:0];
                if (patch)
                    stamped_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ptp_rts_resid.sv
// Rebuilds the 64-bit arrival time from its stored low word and returns the
// correctionField advanced by the residence time plus calibration.
// Assumes the residence time is shorter than one 32-bit wrap (about 4.29 s).
module ptp_rts_resid #(
    parameter int CAL_W = 16
) (
    input  logic [63:0]      now,
    input  logic [31:0]      stored,
    input  logic [CAL_W-1:0] cal,
    input  logic [63:0]      corr_old,
    output logic [63:0]      corr_new
);
    logic        wrapped;
    logic [63:0] rebuilt, resid;

    // Undo one low-word wrap, subtract, calibrate and scale into 2^-16 ns.
    always_comb begin
        wrapped  = (stored > now[31:0]);
        rebuilt  = {now[63:32] - {31'd0, wrapped}, stored};
        resid    = now - rebuilt + 64'(cal);
        corr_new = corr_old + {resid[47:0], 16'd0};
    end
endmodule

// File: rtl/ptp_rts_holdbuf.sv
// Short in-order byte queue. It releases a byte when full or when a frame end
// is queued, and rewrites tagged bytes in place on request. Assumes DEPTH
// covers the span from the correctionField to the end of the reserved field.
module ptp_rts_holdbuf
    import ptp_rts_pkg::*;
#(
    parameter int DEPTH = FIELD_SPAN
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  slot_t       in_slot,
    output logic        out_valid,
    input  logic        out_ready,
    output slot_t       out_slot,
    input  logic        patch_en,
    input  logic [63:0] corr_new,
    input  logic [31:0] rsv_new,
    output logic [63:0] corr_old,
    output logic [31:0] rsv_old
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    slot_t          slots_q [DEPTH];
    slot_t          stage   [DEPTH];
    slot_t          nxt     [DEPTH];
    logic [CW-1:0]  count_q, wr_idx, role_cnt;
    logic           has_last, push, pop;

    // Detect a queued frame end, which allows release before the queue fills.
    always_comb begin
        has_last = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            if (CW'(i) < count_q && slots_q[i].last)
                has_last = 1'b1;
    end

    assign out_valid = (count_q == FULL) || has_last;
    assign in_ready  = (count_q != FULL) || out_ready;
    assign push      = in_valid && in_ready;
    assign pop       = out_valid && out_ready;
    assign out_slot  = slots_q[0];

    // Apply this cycle's pop and push to form the staged contents.
    always_comb begin
        stage = slots_q;
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++)
                stage[i] = slots_q[i + 1];
            stage[DEPTH - 1] = '0;
        end
        wr_idx = count_q - CW'(pop);
        if (push)
            stage[IW'(wr_idx)] = in_slot;
    end

    // Gather the tagged correction and reserved bytes from the staged contents.
    always_comb begin
        corr_old = '0;
        rsv_old  = '0;
        role_cnt = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (stage[i].role != ROLE_NONE)
                role_cnt = role_cnt + 1'b1;
            for (int k = 0; k < 8; k++)
                if (stage[i].role == ROLE_CORR0 + 4'(k))
                    corr_old[63 - 8*k -: 8] = stage[i].data;
            for (int k = 0; k < 4; k++)
                if (stage[i].role == ROLE_RSV0 + 4'(k))
                    rsv_old[31 - 8*k -: 8] = stage[i].data;
        end
    end

    // Rewrite tagged bytes on request and retire tags once a frame closes.
    always_comb begin
        nxt = stage;
        for (int i = 0; i < DEPTH; i++) begin
            if (patch_en) begin
                for (int k = 0; k < 8; k++)
                    if (stage[i].role == ROLE_CORR0 + 4'(k))
                        nxt[i].data = corr_new[63 - 8*k -: 8];
                for (int k = 0; k < 4; k++)
                    if (stage[i].role == ROLE_RSV0 + 4'(k))
                        nxt[i].data = rsv_new[31 - 8*k -: 8];
                nxt[i].role = ROLE_NONE;
            end
            if (push && in_slot.last)
                nxt[i].role = ROLE_NONE;
        end
    end

    // Register the queue contents and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            for (int i = 0; i < DEPTH; i++)
                slots_q[i] <= '0;
        end else begin
            slots_q <= nxt;
            count_q <= count_q + CW'(push) - CW'(pop);
        end
    end

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_slot.data) && $stable(out_slot.last));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= FULL);

    // R5
    patch_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        patch_en |-> role_cnt == CW'(FIELD_SPAN));

    logic [7:0] fin_q, fout_q;
    // Count frame ends entering and leaving, for the ordering check only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fin_q  <= '0;
            fout_q <= '0;
        end else begin
            if (push && in_slot.last) fin_q  <= fin_q + 1'b1;
            if (pop && out_slot.last) fout_q <= fout_q + 1'b1;
        end
    end

    // R7
    frames_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_q - fout_q) <= 8'(DEPTH));
endmodule

// File: rtl/ptp_residence_stamper.sv
// Top of the residence stamper. It classifies and tags bytes, holds them in a
// short queue, and rewrites the reserved field (ingress) or the correctionField
// and reserved field (egress) of PTP event frames. Assumes time_ns is the
// common network time and that egress_mode is changed only between frames.
module ptp_residence_stamper
    import ptp_rts_pkg::*;
#(
    parameter int CAL_W = 16,
    parameter int DEPTH = FIELD_SPAN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             egress_mode,
    input  logic [CAL_W-1:0] cal_ns,
    input  logic [63:0]      time_ns,
    input  logic [7:0]       s_tdata,
    input  logic             s_tvalid,
    output logic             s_tready,
    input  logic             s_tlast,
    output logic [7:0]       m_tdata,
    output logic             m_tvalid,
    input  logic             m_tready,
    output logic             m_tlast,
    output logic [1:0]       m_tuser
);
    logic        beat, patch;
    logic [3:0]  role;
    logic [1:0]  flags;
    logic [63:0] ts, corr_old, corr_calc, corr_new;
    logic [31:0] rsv_old, rsv_new;
    slot_t       in_slot, out_slot;

    assign beat = s_tvalid && s_tready;

    ptp_rts_parser u_parser (
        .clk     (clk),
        .rst_n   (rst_n),
        .beat    (beat),
        .data    (s_tdata),
        .last    (s_tlast),
        .time_ns (time_ns),
        .role    (role),
        .patch   (patch),
        .flags   (flags),
        .ts      (ts)
    );

    ptp_rts_resid #(.CAL_W(CAL_W)) u_resid (
        .now      (ts),
        .stored   (rsv_old),
        .cal      (cal_ns),
        .corr_old (corr_old),
        .corr_new (corr_calc)
    );

    // Select the field contents written back for the configured direction.
    always_comb begin
        in_slot  = '{data: s_tdata, last: s_tlast, user: flags, role: role};
        corr_new = egress_mode ? corr_calc : corr_old;
        rsv_new  = egress_mode ? 32'd0 : ts[31:0];
    end

    ptp_rts_holdbuf #(.DEPTH(DEPTH)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (s_tvalid),
        .in_ready  (s_tready),
        .in_slot   (in_slot),
        .out_valid (m_tvalid),
        .out_ready (m_tready),
        .out_slot  (out_slot),
        .patch_en  (patch),
        .corr_new  (corr_new),
        .rsv_new   (rsv_new),
        .corr_old  (corr_old),
        .rsv_old   (rsv_old)
    );

    assign m_tdata = out_slot.data;
    assign m_tlast = out_slot.last;
    assign m_tuser = out_slot.user;

    // R2
    stamped_ptp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && m_tlast && m_tuser[1] |-> m_tuser[0]);
endmodule

// File: tb/ptp_residence_stamper_tb.sv
// Table-driven bench for the residence stamper, followed by directed cases.
module ptp_residence_stamper_tb_top;
    localparam int CLK_P = 10;

    typedef struct packed {
        logic        eg;
        logic [1:0]  kind;      // 0 EtherType PTP, 1 IPv4/UDP, 2 other EtherType
        logic [3:0]  mt;
        logic [15:0] port;
        logic [63:0] now;
        logic [31:0] rsv_in;
        logic [63:0] corr_in;
        logic [15:0] cal;
        logic [31:0] exp_rsv;
        logic [63:0] exp_corr;
        logic [1:0]  exp_user;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        // R3 ingress EtherType Sync: arrival time written, correction kept
        '{1'b0, 2'd0, 4'd0, 16'd0,   64'h0000_0005_1234_5678, 32'h0, 64'h0000_0000_0001_0000, 16'd0,
          32'h1234_5678, 64'h0000_0000_0001_0000, 2'b11, 8'd3},
        // R1 ingress UDP 319 Delay_Req
        '{1'b0, 2'd1, 4'd1, 16'd319, 64'h0000_0000_FFFF_FFF0, 32'h0, 64'h0, 16'd0,
          32'hFFFF_FFF0, 64'h0, 2'b11, 8'd1},
        // R2 ingress UDP 320: classified, untouched
        '{1'b0, 2'd1, 4'd0, 16'd320, 64'h0000_0000_0000_1000, 32'hAABB_CCDD, 64'h5, 16'd0,
          32'hAABB_CCDD, 64'h5, 2'b01, 8'd2},
        // R2 ingress Announce: classified, untouched
        '{1'b0, 2'd0, 4'hB, 16'd0,   64'h0000_0000_0000_2000, 32'h1122_3344, 64'h7, 16'd0,
          32'h1122_3344, 64'h7, 2'b01, 8'd2},
        // R7 ingress UDP port 1234: not PTP
        '{1'b0, 2'd1, 4'd0, 16'd1234, 64'h0000_0000_0000_3000, 32'h5566_7788, 64'h9, 16'd0,
          32'h5566_7788, 64'h9, 2'b00, 8'd7},
        // R6 egress EtherType Sync, no wrap: residence 0x800
        '{1'b1, 2'd0, 4'd0, 16'd0,   64'h0000_0005_0000_1000, 32'h0000_0800, 64'h0, 16'd0,
          32'h0, 64'h0000_0000_0800_0000, 2'b11, 8'd6},
        // R4 egress UDP 319 across a 32-bit wrap: residence 0x20
        '{1'b1, 2'd1, 4'd0, 16'd319, 64'h0000_0006_0000_0010, 32'hFFFF_FFF0, 64'h0000_0000_0001_0000, 16'd0,
          32'h0, 64'h0000_0000_0021_0000, 2'b11, 8'd4},
        // R5 egress Delay_Req with calibration 100 ns
        '{1'b1, 2'd0, 4'd1, 16'd0,   64'h0000_0000_0000_0300, 32'h0000_0100, 64'h1, 16'd100,
          32'h0, 64'h0000_0000_0264_0001, 2'b11, 8'd5},
        // R2 egress UDP 320: untouched
        '{1'b1, 2'd1, 4'd0, 16'd320, 64'h0000_0001_0000_0000, 32'hDEAD_BEEF, 64'h3, 16'd0,
          32'hDEAD_BEEF, 64'h3, 2'b01, 8'd2},
        // R7 egress other EtherType: untouched
        '{1'b1, 2'd2, 4'd0, 16'd0,   64'h0000_0001_0000_0000, 32'hCAFE_0001, 64'h11, 16'd0,
          32'hCAFE_0001, 64'h11, 2'b00, 8'd7},
        // R2 egress Follow_Up: untouched
        '{1'b1, 2'd0, 4'd8, 16'd0,   64'h0000_0001_0000_0000, 32'h0102_0304, 64'h22, 16'd0,
          32'h0102_0304, 64'h22, 2'b01, 8'd2},
        // R5 egress sum carries out of 64 bits
        '{1'b1, 2'd0, 4'd0, 16'd0,   64'h0000_0000_0000_0002, 32'h0000_0001, 64'hFFFF_FFFF_FFFF_0000, 16'd0,
          32'h0, 64'h0, 2'b11, 8'd5}
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        egress_mode = 1'b0;
    logic [15:0] cal_ns = '0;
    logic [63:0] time_ns = '0;
    logic [7:0]  s_tdata = '0;
    logic        s_tvalid = 1'b0, s_tlast = 1'b0, s_tready;
    logic [7:0]  m_tdata;
    logic        m_tvalid, m_tlast, m_tready = 1'b1;
    logic [1:0]  m_tuser;

    int n_chk = 0, n_fail = 0;
    logic [7:0] tx_b  [128];
    logic [7:0] exp_b [128];
    logic [7:0] rx_b  [128];
    int tx_len = 0, rx_cnt = 0, rx_len = 0, frames_rx = 0;
    logic [1:0] rx_user = '0;
    logic       bp_en = 1'b0;
    logic [7:0] lfsr = 8'h5A;

    always #(CLK_P/2) clk = ~clk;

    ptp_residence_stamper dut_i (
        .clk(clk), .rst_n(rst_n), .egress_mode(egress_mode), .cal_ns(cal_ns),
        .time_ns(time_ns), .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .s_tlast(s_tlast), .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .m_tlast(m_tlast), .m_tuser(m_tuser)
    );

    // Output backpressure: pseudo-random when enabled, else always ready.
    initial begin
        forever begin
            @(posedge clk); #1;
            if (bp_en) begin
                lfsr     = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                m_tready = lfsr[0] | lfsr[2];
            end else begin
                m_tready = 1'b1;
            end
        end
    end

    // Collect output bytes; a transfer seen at the falling edge completes next rise.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && m_tvalid && m_tready) begin
                rx_b[rx_cnt] = m_tdata;
                rx_cnt++;
                if (m_tlast) begin
                    rx_len  = rx_cnt;
                    rx_user = m_tuser;
                    rx_cnt  = 0;
                    frames_rx++;
                end
            end
        end
    end

    // Watchdog: a hang counts as one failed check.
    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL R8 watchdog: actual hang, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    task automatic build(input vec_t v);
        int h;
        h = (v.kind == 2'd1) ? 42 : 14;
        tx_len = h + 44;
        for (int i = 0; i < tx_len; i++) tx_b[i] = 8'(i * 13 + 5);
        if (v.kind == 2'd0) begin tx_b[12] = 8'h88; tx_b[13] = 8'hF7; end
        else if (v.kind == 2'd2) begin tx_b[12] = 8'h08; tx_b[13] = 8'h06; end
        else begin
            tx_b[12] = 8'h08; tx_b[13] = 8'h00; tx_b[14] = 8'h45; tx_b[23] = 8'd17;
            tx_b[36] = v.port[15:8]; tx_b[37] = v.port[7:0];
        end
        tx_b[h] = {4'h2, v.mt};
        for (int k = 0; k < 8; k++) tx_b[h + 8 + k]  = v.corr_in[63 - 8*k -: 8];
        for (int k = 0; k < 4; k++) tx_b[h + 16 + k] = v.rsv_in[31 - 8*k -: 8];
        for (int i = 0; i < tx_len; i++) exp_b[i] = tx_b[i];
        for (int k = 0; k < 8; k++) exp_b[h + 8 + k]  = v.exp_corr[63 - 8*k -: 8];
        for (int k = 0; k < 4; k++) exp_b[h + 16 + k] = v.exp_rsv[31 - 8*k -: 8];
    endtask

    task automatic send_frame();
        logic ok;
        for (int i = 0; i < tx_len; i++) begin
            s_tdata  = tx_b[i];
            s_tlast  = (i == tx_len - 1);
            s_tvalid = 1'b1;
            do begin
                @(negedge clk); ok = s_tready;
                @(posedge clk); #1;
            end while (!ok);
        end
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
    endtask

    task automatic check_frame(input int req, input int tag, input logic [1:0] exp_user);
        int bad;
        bad = -1;
        n_chk++;
        if (rx_len != tx_len) begin
            n_fail++;
            $display("FAIL R%0d case %0d length: actual %0d expected %0d", req, tag, rx_len, tx_len);
        end else begin
            for (int i = 0; i < tx_len; i++)
                if (bad < 0 && rx_b[i] !== exp_b[i]) bad = i;
            if (bad >= 0) begin
                n_fail++;
                $display("FAIL R%0d case %0d byte %0d: actual %02h expected %02h",
                         req, tag, bad, rx_b[bad], exp_b[bad]);
            end
        end
        n_chk++;
        if (rx_user !== exp_user) begin
            n_fail++;
            $display("FAIL R%0d case %0d tuser: actual %b expected %b", req, tag, rx_user, exp_user);
        end
    endtask

    initial begin
        int want;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R10 reset state
        @(negedge clk);
        n_chk++;
        if (m_tvalid !== 1'b0 || s_tready !== 1'b1) begin
            n_fail++;
            $display("FAIL R10 reset: actual valid=%b ready=%b expected valid=0 ready=1", m_tvalid, s_tready);
        end
        @(posedge clk); #1;

        // Walk the table twice: free-flowing output, then with stalls (R8).
        for (int pass = 0; pass < 2; pass++) begin
            bp_en = (pass == 1);
            for (int n = 0; n < NV; n++) begin
                egress_mode = VECS[n].eg;
                cal_ns      = VECS[n].cal;
                time_ns     = VECS[n].now;
                build(VECS[n]);
                want = frames_rx + 1;
                send_frame();
                wait (frames_rx == want);
                @(posedge clk); #1;
                check_frame(pass == 1 ? 8 : int'(VECS[n].req), pass * 100 + n, VECS[n].exp_user);
            end
        end

        // R9 frame shorter than the queue still leaves in full
        bp_en  = 1'b0;
        tx_len = 5;
        for (int i = 0; i < 5; i++) begin tx_b[i] = 8'(8'hF0 + i); exp_b[i] = tx_b[i]; end
        want = frames_rx + 1;
        send_frame();
        wait (frames_rx == want);
        @(posedge clk); #1;
        check_frame(9, 900, 2'b00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule